// File: doc/BRIEF.md
# Pulse-Per-Second Output Generator

This block turns a running time value into a programmable periodic square wave, typically one pulse per second. It watches the time counter's nanosecond and fraction value, which wraps back to zero once per rollover period. It compares that value against a threshold held in 32.32 fixed point. When the time passes the threshold, the output changes level. The threshold then moves forward by one of two programmed increments and wraps modulo the rollover period, so the next compare still lines up with the wrapping counter.

The increment used depends on the level just entered. Entering the active level adds the active-phase length, and entering the idle level adds the idle-phase length. Together the two values set both the period and the duty cycle. With a one-second rollover, two 500 ms phases give a 1 Hz wave with a 50 % duty cycle. Software can rewrite the threshold while the generator runs, which moves the phase of the wave. An enable bit and an invert bit shape the pin. The time counter itself is outside the block.

Top module: `pps_gen`

## Requirements
- R1: After reset the output is 0, the generator is disabled, and the threshold and both increments are zero.
- R2: A write with `wr_addr` 0 loads the control word: bit 30 is enable and bit 31 is invert. Address 1 loads the threshold, address 2 loads the active-phase increment and address 3 loads the idle-phase increment. Each of the last three is a 32.32 value (nanoseconds in the upper half). A control write changes the output from the cycle after the write edge.
- R3: While enabled, the internal level toggles at the clock edge whose time sample crosses the threshold. A crossing means the previous sample is below the threshold and the current sample is at or above it. The output shows the new level after that edge. A time sample equal to the previous one never toggles.
- R4: A toggle into the active level advances the threshold by the active-phase increment. A toggle into the idle level advances it by the idle-phase increment.
- R5: The advanced threshold is reduced modulo the rollover period (ROLLOVER_NS in the nanosecond field). This applies when the threshold and both increments are programmed below the rollover period.
- R6: A crossing is also detected when the time sample wraps past the rollover. This includes a threshold of exactly 0, which then fires on the first sample after the wrap.
- R7: While disabled the output is held at the inactive level, which equals the invert bit, and no toggles occur. The level is reset, so after a new enable the first toggle enters the active level.
- R8: With invert set, the output is the complement of the level while enabled.
- R9: A threshold write takes the place of any toggle that would have happened at the same edge. The level keeps its value, and the new threshold is used from the next sample on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_ns | input | NS_W | Nanosecond part of the running time, wraps at ROLLOVER_NS |
| time_frac | input | FRAC_W | Fraction-of-nanosecond part of the running time |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 threshold, 2 active increment, 3 idle increment |
| wr_data | input | NS_W+FRAC_W | Write data |
| pps_out | output | 1 | Pulse output |

## Verification
The bench runs the generator with a short rollover period and advances the time by a fixed step each cycle. It predicts every output level from an unwrapped absolute time and a list of absolute edge times. Four setups are used:
- equal phases whose edges land exactly on the wrap, which separates correct wrap handling from early or missed edges;
- unequal phases, which shows whether the two increments are swapped;
- phases and time steps with fractional parts together with the invert bit;
- a threshold of zero, which must fire right after a wrap.

Within these runs the bench also disables and re-enables the generator and rewrites the threshold in the very cycle a toggle is due. These steps show that the hold level, the level reset and the cancelled toggle behave as required.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [1:0] {
    PPS_A_CFG = 2'd0,
    PPS_A_THR = 2'd1,
    PPS_A_HI  = 2'd2,
    PPS_A_LO  = 2'd3
  } pps_addr_e;

  localparam int PPS_EN_BIT  = 30;
  localparam int PPS_INV_BIT = 31;
endpackage

// File: rtl/pps_regs.sv
module pps_regs
  import pps_pkg::*;
#(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [TW-1:0] wr_data,
  output logic          en_q,
  output logic          inv_q,
  output logic [TW-1:0] hi_inc_q,
  output logic [TW-1:0] lo_inc_q,
  output logic          thr_wr,
  output logic [TW-1:0] thr_data
);
  pps_addr_e sel;
  assign sel      = pps_addr_e'(wr_addr);
  assign thr_wr   = wr_en && (sel == PPS_A_THR);
  assign thr_data = wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      inv_q    <= 1'b0;
      hi_inc_q <= '0;
      lo_inc_q <= '0;
    end else if (wr_en) begin
      case (sel)
        PPS_A_CFG: begin
          en_q  <= wr_data[PPS_EN_BIT];
          inv_q <= wr_data[PPS_INV_BIT];
        end
        PPS_A_HI: hi_inc_q <= wr_data;
        PPS_A_LO: lo_inc_q <= wr_data;
        default: ;
      endcase
    end
  end

  // R2: a control write lands in the enable and invert flags
  assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0) |=> (en_q == $past(wr_data[PPS_EN_BIT]) &&
                                    inv_q == $past(wr_data[PPS_INV_BIT])));
endmodule

// File: rtl/pps_cross.sv
module pps_cross #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [TW-1:0] cur,
  input  logic [TW-1:0] thr,
  output logic          fire,
  output logic          wrap_ev
);
  logic [TW-1:0] prev_q;
  logic          valid_q;

  // circular crossing test: did the step prev -> cur pass thr
  function automatic logic crossed(logic [TW-1:0] p, logic [TW-1:0] c,
                                   logic [TW-1:0] t);
    if (c >= p) return (t > p) && (t <= c);
    else        return (t > p) || (t <= c);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      prev_q  <= cur;
      valid_q <= 1'b1;
    end
  end

  assign wrap_ev = valid_q && (cur < prev_q);
  assign fire    = en && valid_q && crossed(prev_q, cur, thr);

  // R3: an unchanged time sample never fires
  assert_no_fire_static_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && cur == prev_q) |-> !fire);
  // R6: a zero threshold fires on the first sample after a wrap
  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wrap_ev && thr == '0) |-> fire);
endmodule

// File: rtl/pps_toggle.sv
module pps_toggle #(
  parameter int NS_W        = 32,
  parameter int FRAC_W      = 32,
  parameter int ROLLOVER_NS = 1000000000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   fire,
  input  logic                   thr_wr,
  input  logic [NS_W+FRAC_W-1:0] thr_data,
  input  logic [NS_W+FRAC_W-1:0] hi_inc,
  input  logic [NS_W+FRAC_W-1:0] lo_inc,
  output logic                   level_q,
  output logic [NS_W+FRAC_W-1:0] thr_q,
  output logic                   adv_ev
);
  localparam int TW = NS_W + FRAC_W;
  localparam logic [TW:0] ROLL_FULL = {1'b0, NS_W'(ROLLOVER_NS), {FRAC_W{1'b0}}};

  // next threshold, reduced modulo the rollover period
  function automatic logic [TW-1:0] advance(logic [TW-1:0] t, logic [TW-1:0] inc);
    logic [TW:0] s;
    s = {1'b0, t} + {1'b0, inc};
    if (s >= ROLL_FULL) s = s - ROLL_FULL;
    return s[TW-1:0];
  endfunction

  assign adv_ev = fire && !thr_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q   <= '0;
      level_q <= 1'b0;
    end else begin
      if (thr_wr)      thr_q <= thr_data;
      else if (adv_ev) thr_q <= advance(thr_q, level_q ? lo_inc : hi_inc);
      if (!en)         level_q <= 1'b0;
      else if (adv_ev) level_q <= ~level_q;
    end
  end

  // R3: every accepted crossing flips the level
  assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ev |=> (level_q != $past(level_q)));
  // R3: no crossing, no change while enabled
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_ev && en) |=> $stable(level_q));
  // R5: hardware advance stays inside the rollover period
  assert_thr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ev |=> ({1'b0, thr_q} < ROLL_FULL));
  // R7: disabled generator returns to the idle level
  assert_disabled_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !level_q);
  // R9: threshold write wins over a same-edge toggle
  assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> (thr_q == $past(thr_data) && $stable(level_q)));
endmodule

// File: rtl/pps_gen.sv
module pps_gen #(
  parameter int NS_W        = 32,
  parameter int FRAC_W      = 32,
  parameter int ROLLOVER_NS = 1000000000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NS_W-1:0]        time_ns,
  input  logic [FRAC_W-1:0]      time_frac,
  input  logic                   wr_en,
  input  logic [1:0]             wr_addr,
  input  logic [NS_W+FRAC_W-1:0] wr_data,
  output logic                   pps_out
);
  localparam int TW = NS_W + FRAC_W;

  logic          en_q, inv_q, thr_wr, fire, wrap_ev, adv_ev, level_q;
  logic [TW-1:0] hi_inc, lo_inc, thr_data, thr_q, cur;

  assign cur = {time_ns, time_frac};

  pps_regs #(.TW(TW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en_q(en_q), .inv_q(inv_q), .hi_inc_q(hi_inc), .lo_inc_q(lo_inc),
    .thr_wr(thr_wr), .thr_data(thr_data)
  );

  pps_cross #(.TW(TW)) u_cross (
    .clk(clk), .rst_n(rst_n), .en(en_q), .cur(cur), .thr(thr_q),
    .fire(fire), .wrap_ev(wrap_ev)
  );

  pps_toggle #(.NS_W(NS_W), .FRAC_W(FRAC_W), .ROLLOVER_NS(ROLLOVER_NS)) u_toggle (
    .clk(clk), .rst_n(rst_n), .en(en_q), .fire(fire), .thr_wr(thr_wr),
    .thr_data(thr_data), .hi_inc(hi_inc), .lo_inc(lo_inc),
    .level_q(level_q), .thr_q(thr_q), .adv_ev(adv_ev)
  );

  assign pps_out = (level_q & en_q) ^ inv_q;

  // R6: a wrap with a crossing produces a level change
  assert_wrap_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_ev && adv_ev) |=> (level_q != $past(level_q)));
  // R1: disabled and not inverted means a low pin
  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !inv_q) |-> !pps_out);
endmodule

// File: tb/pps_gen_bench.sv
`timescale 1ns/1ps
module pps_gen_bench;
  localparam int NS_W = 32, FRAC_W = 32, ROLL = 1000;
  localparam logic [63:0] R64 = 64'(ROLL) << 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] time_ns = '0, time_frac = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic pps_out;

  pps_gen #(.NS_W(NS_W), .FRAC_W(FRAC_W), .ROLLOVER_NS(ROLL)) u_pps_gen (
    .clk(clk), .rst_n(rst_n), .time_ns(time_ns), .time_frac(time_frac),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pps_out(pps_out)
  );

  always #2.5 clk = ~clk;

  int total = 0, failed = 0;
  string tag = "R1";
  logic [63:0] abs_t = '0, next_edge = '0, m_hi = '0, m_lo = '0;
  logic m_en = 1'b0, m_inv = 1'b0, par = 1'b0;

  function automatic logic [63:0] ns(int v);
    return 64'(v) << 32;
  endfunction

  function automatic logic [63:0] next_abs(logic [63:0] w);
    logic [63:0] x;
    x = abs_t - (abs_t % R64) + w;
    if (x <= abs_t) x = x + R64;
    return x;
  endfunction

  task automatic check(logic exp);
    total++;
    if (pps_out !== exp) begin
      failed++;
      $display("FAIL %s t=%0d: pps_out=%0b expected=%0b", tag, abs_t >> 32, pps_out, exp);
    end
  endtask

  function automatic logic expect_out();
    return m_en ? (par ^ m_inv) : m_inv;
  endfunction

  task automatic drive_time();
    logic [63:0] w;
    w = abs_t % R64;
    time_ns   = w[63:32];
    time_frac = w[31:0];
  endtask

  task automatic model_step(logic [63:0] step);
    abs_t = abs_t + step;
    if (m_en && abs_t >= next_edge) begin
      par = ~par;
      next_edge = next_edge + (par ? m_hi : m_lo);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [63:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_cfg(logic en, logic inv);
    wr(2'd0, (64'(inv) << 31) | (64'(en) << 30));
    if (en && !m_en) begin
      par = 1'b0;
      next_edge = next_abs(next_edge % R64);
    end
    if (!en) par = 1'b0;
    m_en = en; m_inv = inv;
    check(expect_out());
  endtask

  task automatic run(int n, logic [63:0] step);
    for (int i = 0; i < n; i++) begin
      model_step(step);
      drive_time();
      @(negedge clk);
      check(expect_out());
    end
  endtask

  task automatic setup(logic [63:0] hi, logic [63:0] lo, logic [63:0] thr, logic inv);
    set_cfg(1'b0, 1'b0);
    wr(2'd2, hi); m_hi = hi;
    wr(2'd3, lo); m_lo = lo;
    wr(2'd1, thr);
    next_edge = next_abs(thr);
    set_cfg(1'b1, inv);
  endtask

  initial begin
    #(200000 * 5);
    failed++; total++;
    $display("FAIL watchdog expired: finished=0 expected=1");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1 reset"; check(1'b0);
    rst_n = 1'b1;
    @(negedge clk); check(1'b0);
    repeat (2) @(negedge clk); check(1'b0);

    // R2 R8: invert bit alone drives the inactive (inverted) level
    tag = "R2 R8 idle invert"; set_cfg(1'b0, 1'b1);
    tag = "R2 idle plain";     set_cfg(1'b0, 1'b0);

    // R3 R5 R6: equal phases, edges land exactly on the wrap
    tag = "R3 R5 R6 equal";
    setup(ns(500), ns(500), ns(500), 1'b0);
    run(700, ns(10));

    // R4: unequal phases, unaligned step
    tag = "R4 asym";
    setup(ns(300), ns(700), ns(250), 1'b0);
    run(600, ns(7));

    // R7: disable with invert, hold, then re-enable starting with active edge
    tag = "R7 disabled";
    set_cfg(1'b0, 1'b1);
    run(250, ns(7));
    tag = "R7 reenable";
    set_cfg(1'b1, 1'b0);
    run(300, ns(7));

    // R9: threshold write on the edge where a toggle is due
    tag = "R9 cancel";
    while (abs_t + ns(7) < next_edge) run(1, ns(7));
    abs_t = abs_t + ns(7);
    drive_time();
    wr(2'd1, (abs_t + ns(300)) % R64);
    next_edge = next_abs((abs_t + ns(300)) % R64);
    check(expect_out());
    run(400, ns(7));

    // R8: fractional phases and step, inverted
    tag = "R8 frac invert";
    setup(ns(250) | 64'h8000_0000, ns(249) | 64'h8000_0000, ns(100), 1'b1);
    run(800, ns(3) | 64'h4000_0000);

    // R6: threshold zero fires right after the wrap
    tag = "R6 thr zero";
    setup(ns(100), ns(150), 64'd0, 1'b0);
    run(700, ns(13));

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule